// File: doc/BRIEF.md
# Bayer Mosaic to RGB Interpolator

This block turns a single-channel colour-filter-array video stream into full RGB. Each incoming 10-bit sample carries only one colour, laid out in a fixed two-line pattern. The first line of every frame alternates blue and green. The line after it alternates green and red. The pattern then repeats. For every pixel the block estimates the two colours the sensor did not measure, from the neighbouring samples inside a 3x3 window. It emits one 30-bit RGB beat per input sample.

Input and output are AXI4-Stream. TUSER marks the first pixel of a frame and TLAST marks the last pixel of a line, on both sides. Three line memories hold the rows that the window needs. Where the window reaches past the frame edge, the nearest in-frame sample is used. The frame geometry is set by the `IMG_W` and `IMG_H` parameters. The incoming framing must match them. Both sides honour TVALID/TREADY flow control.

Top module: `bayer_demosaic`

## Requirements
- R1: After reset the output valid is low and the input ready is high.
- R2: At a blue site (even line, even column, both counted from 0 at the frame start), blue is the centre sample. Green is the floor of the mean of the four orthogonal neighbours. Red is the floor of the mean of the four diagonal neighbours. Output packing is red in bits 29:20, green in bits 19:10 and blue in bits 9:0.
- R3: At a red site (odd line, odd column), red is the centre sample. Green is the floor mean of the four orthogonal neighbours. Blue is the floor mean of the four diagonal neighbours.
- R4: At a green site, green is the centre sample. On an even line, blue is the floor mean of the left and right neighbours and red is the floor mean of the neighbours above and below. On an odd line, red is the floor mean of the left and right neighbours and blue is the floor mean of the neighbours above and below.
- R5: A neighbour outside the frame takes the value of the in-frame sample at the clamped coordinate. A frame of `IMG_W` x `IMG_H` input samples yields exactly `IMG_W` x `IMG_H` output beats.
- R6: Output TUSER is high on the first beat of each frame and on no other beat. Output TLAST is high exactly on the beats of column `IMG_W`-1.
- R7: While output valid is high and ready is low, the data, TUSER and TLAST hold steady. Every accepted input sample produces exactly one output beat, in raster order, with none dropped or repeated.
- R8: The colour phase restarts at every frame, whatever the parity of the frame height: the first line after a frame boundary is a blue-green line. An input beat with TUSER is taken as line 0, column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_axis_tvalid | input | 1 | Input sample valid |
| s_axis_tready | output | 1 | Block can accept an input sample |
| s_axis_tdata | input | 10 | Raw mosaic sample |
| s_axis_tuser | input | 1 | First sample of a frame |
| s_axis_tlast | input | 1 | Last sample of a line |
| m_axis_tvalid | output | 1 | Output pixel valid |
| m_axis_tready | input | 1 | Downstream accepts the pixel |
| m_axis_tdata | output | 30 | RGB pixel, red in the top bits |
| m_axis_tuser | output | 1 | First pixel of a frame |
| m_axis_tlast | output | 1 | Last pixel of a line |

## Verification
The bench builds the block with a 6-column, 5-line frame. Six columns give each line interior pixels of both site kinds next to two clamped edge columns. The odd height means a phase counter that failed to restart would start the next frame on a green-red line. At this size all thirty positions of every frame are checked against an arithmetic model. The eight frames cover ramps, saturated and zero fields, a single bright spike, a checkerboard and a hashed pattern. Later frames add input gaps and heavy output stalls, so hold-steady behaviour and beat ordering are exercised at every position in the frame.

// File: rtl/bayer_dm_pkg.sv
package bayer_dm_pkg;

    localparam int PIX_W = 10;
    localparam int RGB_W = 3 * PIX_W;
    localparam int TAPS  = 3;

    typedef logic [PIX_W-1:0] pix_t;
    typedef logic [1:0]       slot_t;

    // red occupies the most significant field of the output beat
    typedef struct packed {
        pix_t r;
        pix_t g;
        pix_t b;
    } rgb_t;

    // encoding is {line odd, column odd}
    typedef enum logic [1:0] {
        SITE_BLUE   = 2'd0,
        SITE_G_ON_B = 2'd1,
        SITE_G_ON_R = 2'd2,
        SITE_RED    = 2'd3
    } site_e;

    typedef struct packed {
        pix_t nw, n, ne;
        pix_t w,  c, e;
        pix_t sw, s, se;
    } win_t;

    function automatic site_e site_of(input logic row_odd, input logic col_odd);
        return site_e'({row_odd, col_odd});
    endfunction

    function automatic pix_t mean2(input pix_t a, input pix_t b);
        logic [PIX_W:0] sum;
        sum = {1'b0, a} + {1'b0, b};
        return sum[PIX_W:1];
    endfunction

    function automatic pix_t mean4(input pix_t a, input pix_t b,
                                   input pix_t c, input pix_t d);
        logic [PIX_W+1:0] sum;
        sum = {2'b00, a} + {2'b00, b} + {2'b00, c} + {2'b00, d};
        return sum[PIX_W+1:2];
    endfunction

    function automatic rgb_t interp(input win_t w, input site_e site);
        rgb_t o;
        case (site)
            SITE_BLUE: begin
                o.r = mean4(w.nw, w.ne, w.sw, w.se);
                o.g = mean4(w.n, w.s, w.w, w.e);
                o.b = w.c;
            end
            SITE_G_ON_B: begin
                o.r = mean2(w.n, w.s);
                o.g = w.c;
                o.b = mean2(w.w, w.e);
            end
            SITE_G_ON_R: begin
                o.r = mean2(w.w, w.e);
                o.g = w.c;
                o.b = mean2(w.n, w.s);
            end
            default: begin
                o.r = w.c;
                o.g = mean4(w.n, w.s, w.w, w.e);
                o.b = mean4(w.nw, w.ne, w.sw, w.se);
            end
        endcase
        return o;
    endfunction

    function automatic slot_t slot_next(input slot_t s);
        return (s == slot_t'(TAPS - 1)) ? slot_t'(0) : s + slot_t'(1);
    endfunction

    function automatic slot_t slot_prev(input slot_t s);
        return (s == slot_t'(0)) ? slot_t'(TAPS - 1) : s - slot_t'(1);
    endfunction

endpackage

// File: rtl/bayer_dm_in_track.sv
module bayer_dm_in_track
    import bayer_dm_pkg::*;
#(
    parameter int IMG_W = 1280,
    parameter int IMG_H = 720
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       s_valid,
    output logic                       s_ready,
    input  logic                       s_user,
    input  logic                       s_last,
    input  logic [$clog2(IMG_H)-1:0]   out_row,
    input  logic                       frame_release,
    output logic                       wr_en,
    output slot_t                      wr_slot,
    output logic [$clog2(IMG_W)-1:0]   wr_col,
    output logic [$clog2(IMG_H)-1:0]   in_row,
    output logic [$clog2(IMG_W)-1:0]   in_col,
    output logic                       in_done
);

    localparam int CW = $clog2(IMG_W);
    localparam int RW = $clog2(IMG_H);
    localparam logic [RW-1:0] LAST_ROW = RW'(IMG_H - 1);

    logic [CW-1:0] col_q;
    logic [RW-1:0] row_q;
    slot_t         slot_q;
    logic          done_q;

    logic [CW-1:0] eff_col;
    logic [RW-1:0] eff_row;
    slot_t         eff_slot;
    logic [RW:0]   row_limit;
    logic          fire;

    // a line may be written once the rows it overwrites are no longer read
    assign row_limit = {1'b0, out_row} + {{RW{1'b0}}, 1'b1};
    assign s_ready   = !done_q && ({1'b0, row_q} <= row_limit);
    assign fire      = s_valid && s_ready;

    // frame start marker forces the write position to the origin
    assign eff_col  = s_user ? '0 : col_q;
    assign eff_row  = s_user ? '0 : row_q;
    assign eff_slot = s_user ? slot_t'(0) : slot_q;

    assign wr_en   = fire;
    assign wr_slot = eff_slot;
    assign wr_col  = eff_col;
    assign in_row  = row_q;
    assign in_col  = col_q;
    assign in_done = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q  <= '0;
            row_q  <= '0;
            slot_q <= slot_t'(0);
            done_q <= 1'b0;
        end else begin
            if (frame_release) begin
                done_q <= 1'b0;
            end
            if (fire) begin
                if (s_last) begin
                    col_q <= '0;
                    if (eff_row == LAST_ROW) begin
                        row_q  <= '0;
                        slot_q <= slot_t'(0);
                        done_q <= 1'b1;
                    end else begin
                        row_q  <= eff_row + 1'b1;
                        slot_q <= slot_next(eff_slot);
                    end
                end else begin
                    col_q  <= eff_col + 1'b1;
                    row_q  <= eff_row;
                    slot_q <= eff_slot;
                end
            end
        end
    end

endmodule

// File: rtl/bayer_dm_linestore.sv
module bayer_dm_linestore
    import bayer_dm_pkg::*;
#(
    parameter int IMG_W = 1280
) (
    input  logic                       clk,
    input  logic                       wr_en,
    input  slot_t                      wr_slot,
    input  logic [$clog2(IMG_W)-1:0]   wr_col,
    input  pix_t                       wr_data,
    input  slot_t                      rd_slot_up,
    input  slot_t                      rd_slot_mid,
    input  slot_t                      rd_slot_dn,
    input  logic [$clog2(IMG_W)-1:0]   rd_col_l,
    input  logic [$clog2(IMG_W)-1:0]   rd_col_c,
    input  logic [$clog2(IMG_W)-1:0]   rd_col_r,
    output win_t                       win
);

    pix_t tap [TAPS][TAPS];

    for (genvar g = 0; g < TAPS; g++) begin : g_line
        pix_t mem [IMG_W];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_slot == slot_t'(g))) begin
                mem[wr_col] <= wr_data;
            end
        end

        assign tap[g][0] = mem[rd_col_l];
        assign tap[g][1] = mem[rd_col_c];
        assign tap[g][2] = mem[rd_col_r];
    end

    function automatic pix_t pick(input slot_t s, input pix_t a, input pix_t b, input pix_t c);
        case (s)
            2'd1:    return b;
            2'd2:    return c;
            default: return a;
        endcase
    endfunction

    always_comb begin
        win.nw = pick(rd_slot_up,  tap[0][0], tap[1][0], tap[2][0]);
        win.n  = pick(rd_slot_up,  tap[0][1], tap[1][1], tap[2][1]);
        win.ne = pick(rd_slot_up,  tap[0][2], tap[1][2], tap[2][2]);
        win.w  = pick(rd_slot_mid, tap[0][0], tap[1][0], tap[2][0]);
        win.c  = pick(rd_slot_mid, tap[0][1], tap[1][1], tap[2][1]);
        win.e  = pick(rd_slot_mid, tap[0][2], tap[1][2], tap[2][2]);
        win.sw = pick(rd_slot_dn,  tap[0][0], tap[1][0], tap[2][0]);
        win.s  = pick(rd_slot_dn,  tap[0][1], tap[1][1], tap[2][1]);
        win.se = pick(rd_slot_dn,  tap[0][2], tap[1][2], tap[2][2]);
    end

endmodule

// File: rtl/bayer_dm_out_seq.sv
module bayer_dm_out_seq
    import bayer_dm_pkg::*;
#(
    parameter int IMG_W = 1280,
    parameter int IMG_H = 720
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [$clog2(IMG_H)-1:0]   in_row,
    input  logic [$clog2(IMG_W)-1:0]   in_col,
    input  logic                       in_done,
    input  logic                       m_ready,
    input  win_t                       win,
    output slot_t                      rd_slot_up,
    output slot_t                      rd_slot_mid,
    output slot_t                      rd_slot_dn,
    output logic [$clog2(IMG_W)-1:0]   rd_col_l,
    output logic [$clog2(IMG_W)-1:0]   rd_col_c,
    output logic [$clog2(IMG_W)-1:0]   rd_col_r,
    output logic [$clog2(IMG_H)-1:0]   out_row,
    output logic                       frame_release,
    output logic                       m_valid,
    output rgb_t                       m_pix,
    output logic                       m_user,
    output logic                       m_last
);

    localparam int CW = $clog2(IMG_W);
    localparam int RW = $clog2(IMG_H);
    localparam logic [CW-1:0] LAST_COL = CW'(IMG_W - 1);
    localparam logic [RW-1:0] LAST_ROW = RW'(IMG_H - 1);

    logic [CW-1:0] ox_q;
    logic [RW-1:0] oy_q;
    slot_t         oslot_q;
    logic          valid_q;
    rgb_t          pix_q;
    logic          user_q;
    logic          last_q;

    logic [RW-1:0] need_row;
    logic [CW-1:0] need_col;
    logic          avail;
    logic          load;
    logic          at_col_end;
    logic          at_row_end;

    assign at_col_end = (ox_q == LAST_COL);
    assign at_row_end = (oy_q == LAST_ROW);

    // clamped window bounds: the far row and column the window touches
    assign need_row = at_row_end ? oy_q : oy_q + 1'b1;
    assign need_col = at_col_end ? ox_q : ox_q + 1'b1;

    assign avail = in_done
                || (in_row > need_row)
                || ((in_row == need_row) && (in_col > need_col));

    assign rd_slot_mid = oslot_q;
    assign rd_slot_up  = (oy_q == '0) ? oslot_q : slot_prev(oslot_q);
    assign rd_slot_dn  = at_row_end   ? oslot_q : slot_next(oslot_q);
    assign rd_col_c    = ox_q;
    assign rd_col_l    = (ox_q == '0) ? ox_q : ox_q - 1'b1;
    assign rd_col_r    = need_col;

    assign load          = avail && (!valid_q || m_ready);
    assign frame_release = load && at_col_end && at_row_end;
    assign out_row       = oy_q;

    assign m_valid = valid_q;
    assign m_pix   = pix_q;
    assign m_user  = user_q;
    assign m_last  = last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ox_q    <= '0;
            oy_q    <= '0;
            oslot_q <= slot_t'(0);
            valid_q <= 1'b0;
            pix_q   <= '0;
            user_q  <= 1'b0;
            last_q  <= 1'b0;
        end else if (load) begin
            pix_q   <= interp(win, site_of(oy_q[0], ox_q[0]));
            user_q  <= (ox_q == '0) && (oy_q == '0);
            last_q  <= at_col_end;
            valid_q <= 1'b1;
            if (at_col_end) begin
                ox_q <= '0;
                if (at_row_end) begin
                    oy_q    <= '0;
                    oslot_q <= slot_t'(0);
                end else begin
                    oy_q    <= oy_q + 1'b1;
                    oslot_q <= slot_next(oslot_q);
                end
            end else begin
                ox_q <= ox_q + 1'b1;
            end
        end else if (m_ready) begin
            valid_q <= 1'b0;
        end
    end

endmodule

// File: rtl/bayer_demosaic.sv
module bayer_demosaic
    import bayer_dm_pkg::*;
#(
    parameter int IMG_W = 1280,
    parameter int IMG_H = 720
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 s_axis_tvalid,
    output logic                 s_axis_tready,
    input  logic [PIX_W-1:0]     s_axis_tdata,
    input  logic                 s_axis_tuser,
    input  logic                 s_axis_tlast,
    output logic                 m_axis_tvalid,
    input  logic                 m_axis_tready,
    output logic [RGB_W-1:0]     m_axis_tdata,
    output logic                 m_axis_tuser,
    output logic                 m_axis_tlast
);

    localparam int CW = $clog2(IMG_W);
    localparam int RW = $clog2(IMG_H);

    logic          wr_en;
    slot_t         wr_slot;
    logic [CW-1:0] wr_col;
    logic [RW-1:0] in_row;
    logic [CW-1:0] in_col;
    logic          in_done;
    logic [RW-1:0] out_row;
    logic          frame_release;
    slot_t         rd_slot_up, rd_slot_mid, rd_slot_dn;
    logic [CW-1:0] rd_col_l, rd_col_c, rd_col_r;
    win_t          win;
    rgb_t          m_pix;

    bayer_dm_in_track #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_in (
        .clk           (clk),
        .rst           (rst),
        .s_valid       (s_axis_tvalid),
        .s_ready       (s_axis_tready),
        .s_user        (s_axis_tuser),
        .s_last        (s_axis_tlast),
        .out_row       (out_row),
        .frame_release (frame_release),
        .wr_en         (wr_en),
        .wr_slot       (wr_slot),
        .wr_col        (wr_col),
        .in_row        (in_row),
        .in_col        (in_col),
        .in_done       (in_done)
    );

    bayer_dm_linestore #(.IMG_W(IMG_W)) u_store (
        .clk         (clk),
        .wr_en       (wr_en),
        .wr_slot     (wr_slot),
        .wr_col      (wr_col),
        .wr_data     (s_axis_tdata),
        .rd_slot_up  (rd_slot_up),
        .rd_slot_mid (rd_slot_mid),
        .rd_slot_dn  (rd_slot_dn),
        .rd_col_l    (rd_col_l),
        .rd_col_c    (rd_col_c),
        .rd_col_r    (rd_col_r),
        .win         (win)
    );

    bayer_dm_out_seq #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_out (
        .clk           (clk),
        .rst           (rst),
        .in_row        (in_row),
        .in_col        (in_col),
        .in_done       (in_done),
        .m_ready       (m_axis_tready),
        .win           (win),
        .rd_slot_up    (rd_slot_up),
        .rd_slot_mid   (rd_slot_mid),
        .rd_slot_dn    (rd_slot_dn),
        .rd_col_l      (rd_col_l),
        .rd_col_c      (rd_col_c),
        .rd_col_r      (rd_col_r),
        .out_row       (out_row),
        .frame_release (frame_release),
        .m_valid       (m_axis_tvalid),
        .m_pix         (m_pix),
        .m_user        (m_axis_tuser),
        .m_last        (m_axis_tlast)
    );

    assign m_axis_tdata = m_pix;

endmodule

// File: rtl/bayer_demosaic_chk.sv
module bayer_demosaic_chk #(
    parameter int IMG_W = 1280,
    parameter int IMG_H = 720
) (
    input logic        clk,
    input logic        rst,
    input logic        s_valid,
    input logic        s_ready,
    input logic        m_valid,
    input logic        m_ready,
    input logic [29:0] m_data,
    input logic        m_user,
    input logic        m_last
);

    localparam logic [31:0] LAST_COL   = 32'(IMG_W - 1);
    localparam logic [31:0] LAST_BEAT  = 32'(IMG_W * IMG_H - 1);

    logic [31:0] col_cnt;
    logic [31:0] beat_cnt;
    logic [31:0] acc_cnt;
    logic [31:0] emit_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            col_cnt  <= '0;
            beat_cnt <= '0;
            acc_cnt  <= '0;
            emit_cnt <= '0;
        end else begin
            if (s_valid && s_ready) begin
                acc_cnt <= acc_cnt + 1;
            end
            if (m_valid && m_ready) begin
                emit_cnt <= emit_cnt + 1;
                col_cnt  <= m_last ? '0 : col_cnt + 1;
                beat_cnt <= (beat_cnt == LAST_BEAT) ? '0 : beat_cnt + 1;
            end
        end
    end

    // R1: reset leaves the output idle and the input open
    p_idle_after_reset_r1: assert property (@(posedge clk)
        rst |=> (!m_valid && s_ready));

    // R7: a stalled beat holds its payload and sideband
    p_hold_when_stalled_r7: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_user) && $stable(m_last)));

    // R7: no output beat is presented before its input sample arrived
    p_no_early_beat_r7: assert property (@(posedge clk) disable iff (rst)
        m_valid |-> (acc_cnt > emit_cnt));

    // R6: end-of-line marker sits on the last column only
    p_last_on_end_col_r6: assert property (@(posedge clk) disable iff (rst)
        m_valid |-> (m_last == (col_cnt == LAST_COL)));

    // R6: start-of-frame marker sits on the first beat of each frame only
    p_user_on_first_beat_r6: assert property (@(posedge clk) disable iff (rst)
        m_valid |-> (m_user == (beat_cnt == '0)));

endmodule

bind bayer_demosaic bayer_demosaic_chk #(.IMG_W(IMG_W), .IMG_H(IMG_H)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .s_valid (s_axis_tvalid),
    .s_ready (s_axis_tready),
    .m_valid (m_axis_tvalid),
    .m_ready (m_axis_tready),
    .m_data  (m_axis_tdata),
    .m_user  (m_axis_tuser),
    .m_last  (m_axis_tlast)
);

// File: tb/bayer_demosaic_tb.sv
`timescale 1ns/1ps
module bayer_demosaic_tb_top;

    localparam int TW    = 6;
    localparam int TH    = 5;
    localparam int NF    = 8;
    localparam int FRAME = TW * TH;
    localparam int TOTAL = NF * FRAME;
    localparam int WATCHDOG = 50000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [9:0]  s_data = '0;
    logic        s_user = 1'b0;
    logic        s_last = 1'b0;
    logic        m_valid;
    logic        m_ready = 1'b0;
    logic [29:0] m_data;
    logic        m_user;
    logic        m_last;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bayer_demosaic #(.IMG_W(TW), .IMG_H(TH)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .s_axis_tvalid (s_valid),
        .s_axis_tready (s_ready),
        .s_axis_tdata  (s_data),
        .s_axis_tuser  (s_user),
        .s_axis_tlast  (s_last),
        .m_axis_tvalid (m_valid),
        .m_axis_tready (m_ready),
        .m_axis_tdata  (m_data),
        .m_axis_tuser  (m_user),
        .m_axis_tlast  (m_last)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic int pix(input int f, input int y, input int x);
        case (f % 6)
            0:       return (x * 37 + y * 101 + f * 53 + 5) % 1024;
            1:       return 1023;
            2:       return 0;
            3:       return ((x * 7919 + y * 4241 + f * 13) ^ (x * y * 31)) & 1023;
            4:       return (x == 2 && y == 2) ? 1023 : 0;
            default: return (((x + y) % 2) == 1) ? 1000 : 3;
        endcase
    endfunction

    // edge replication: coordinates clamp into the frame
    function automatic int pc(input int f, input int y, input int x);
        int cy, cx;
        cy = (y < 0) ? 0 : ((y > TH - 1) ? TH - 1 : y);
        cx = (x < 0) ? 0 : ((x > TW - 1) ? TW - 1 : x);
        return pix(f, cy, cx);
    endfunction

    function automatic logic [29:0] expect_rgb(input int f, input int y, input int x);
        int c, n, s, w, e, nw, ne, sw, se, r, g, b;
        c  = pc(f, y, x);
        n  = pc(f, y - 1, x);     s  = pc(f, y + 1, x);
        w  = pc(f, y, x - 1);     e  = pc(f, y, x + 1);
        nw = pc(f, y - 1, x - 1); ne = pc(f, y - 1, x + 1);
        sw = pc(f, y + 1, x - 1); se = pc(f, y + 1, x + 1);
        if (y % 2 == 0 && x % 2 == 0) begin
            r = (nw + ne + sw + se) / 4; g = (n + s + w + e) / 4; b = c;
        end else if (y % 2 == 0) begin
            r = (n + s) / 2; g = c; b = (w + e) / 2;
        end else if (x % 2 == 0) begin
            r = (w + e) / 2; g = c; b = (n + s) / 2;
        end else begin
            r = c; g = (n + s + w + e) / 4; b = (nw + ne + sw + se) / 4;
        end
        return {10'(r), 10'(g), 10'(b)};
    endfunction

    function automatic string tag_of(input int f, input int y, input int x);
        string t;
        if (x == 0 || x == TW - 1 || y == 0 || y == TH - 1) t = "R5";
        else if (y % 2 == 0 && x % 2 == 0) t = "R2";
        else if (y % 2 == 1 && x % 2 == 1) t = "R3";
        else t = "R4";
        if (f > 0 && y == 0) t = {t, "/R8"};
        return t;
    endfunction

    initial begin
        int in_idx, out_idx, cyc;
        bit prev_stall;
        logic [29:0] prev_data;
        logic prev_user, prev_last;
        bit extra;

        in_idx = 0; out_idx = 0; cyc = 0;
        prev_stall = 0; prev_data = '0; prev_user = 0; prev_last = 0;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(m_valid == 1'b0, "R1", "output valid after reset", 32'(m_valid), 32'd0);
        check(s_ready == 1'b1, "R1", "input ready after reset", 32'(s_ready), 32'd1);

        while (out_idx < TOTAL && cyc < WATCHDOG) begin
            int fo, fi, ro, ri;
            bit rdy, want;
            cyc++;
            fo = out_idx / FRAME;
            fi = in_idx / FRAME;

            // output side
            if (prev_stall) begin
                check(m_valid && m_data == prev_data && m_user == prev_user && m_last == prev_last,
                      "R7", "stalled beat held", 32'(m_data), 32'(prev_data));
            end
            if (fo < 2)      rdy = 1'b1;
            else if (fo < 5) rdy = (cyc % 3) != 0;
            else             rdy = (cyc % 7) < 2;
            m_ready = rdy;
            if (m_valid) begin
                if (rdy) begin
                    int y, x;
                    ro = out_idx % FRAME;
                    y = ro / TW;
                    x = ro % TW;
                    check(m_data == expect_rgb(fo, y, x), tag_of(fo, y, x),
                          $sformatf("pixel f%0d y%0d x%0d", fo, y, x),
                          32'(m_data), 32'(expect_rgb(fo, y, x)));
                    check(m_user == (ro == 0) && m_last == (x == TW - 1), "R6",
                          $sformatf("sideband f%0d y%0d x%0d", fo, y, x),
                          {30'd0, m_user, m_last}, {30'd0, 1'(ro == 0), 1'(x == TW - 1)});
                    out_idx++;
                end
                prev_stall = !rdy;
                prev_data  = m_data;
                prev_user  = m_user;
                prev_last  = m_last;
            end else begin
                prev_stall = 1'b0;
            end

            // input side
            if (fi < 2)      want = 1'b1;
            else if (fi < 5) want = (cyc % 5) != 1;
            else             want = 1'b1;
            if (in_idx < TOTAL && want) begin
                int y, x;
                ri = in_idx % FRAME;
                y = ri / TW;
                x = ri % TW;
                s_valid = 1'b1;
                s_data  = 10'(pix(fi, y, x));
                s_user  = (ri == 0);
                s_last  = (x == TW - 1);
                if (s_ready) in_idx++;
            end else begin
                s_valid = 1'b0;
                s_user  = 1'b0;
                s_last  = 1'b0;
            end
            @(negedge clk);
        end

        if (cyc >= WATCHDOG) begin
            check(1'b0, "R7", "watchdog expired before all beats", 32'(out_idx), 32'(TOTAL));
        end

        s_valid = 1'b0;
        m_ready = 1'b1;
        extra = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (m_valid) extra = 1'b1;
        end
        check(!extra, "R7", "no beat beyond the frames sent", 32'(extra), 32'd0);
        check(in_idx == TOTAL && out_idx == TOTAL, "R5", "beat count in equals out",
              32'(out_idx), 32'(in_idx));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule